// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that copies data between memory locations by following a chain of transfer records held in memory. Each record is four 32-bit words. The words are a control word, the address of the last source element, the address of the last destination element, and a pointer to the next record. The channel reads each record through a single valid/ready memory port. It works out where the transfer starts, then moves the elements one at a time: one read, then one write. When a record runs out, the channel can follow the pointer to the next record.

A pulse on `start_i` sends the channel to fetch its first record. That record sits at a fixed slot: the table base plus sixteen bytes times the channel number. A record can start moving data on its own. Otherwise it waits for a single pulse on the ready-made request strobe `req_i`. While the channel runs, `remain_o` shows how many elements of the current record are still to be moved.

On completion the channel can raise two separate flags. An address that does not fit the element width stops the channel and raises an error flag.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, `busy_o`, `remain_o`, `irq_a_o`, `irq_b_o`, `err_o` and `mem_req_o` are all zero.
- R2: A `start_i` pulse while idle makes the channel read four words in order at byte addresses FIRST, FIRST+4, FIRST+8 and FIRST+12. FIRST is `TABLE_BASE + 16*CHAN_ID` (0x210 by default). The words are control, last source address, last destination address and next-record pointer.
- R3: The stored addresses belong to the final element. The element count is control bits [25:16] plus one. The first address is the stored address minus (count-1) times the stride. Elements are moved in ascending order from first to last.
- R4: Stride = step factor × element size. Element size comes from control bits [6:5]: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Source step is control bits [9:8] and destination step is bits [13:12], with codes 0, 1, 2, 3 meaning factors 0, 1, 2, 4. A factor of 0 holds the address fixed, so later writes to a fixed destination overwrite earlier ones.
- R5: Memory addresses on the port are word aligned. A sub-word element is taken from byte lane addr[1:0] of the read word. It is written with `mem_be_o` set only on its own lanes.
- R6: If control bit 2 (self start) is clear, the channel stays busy after the fetch. It makes no data access, with `remain_o` equal to the count, until a one-cycle `req_i` pulse arrives. If bit 2 is set, the channel moves data at once.
- R7: `remain_o` is loaded with the count when data movement is set up and drops by one per completed write. It reads 0 once the record is finished.
- R8: When a record finishes, `irq_a_o` is set if control bit 3 is set and `irq_b_o` is set if control bit 4 is set. Each flag stays set until the next accepted `start_i`.
- R9: If control bit 1 (chain) is set, the finishing record is followed by a fetch of four words at the next-record pointer. Processing then continues with that record.
- R10: A record whose control bit 0 (valid) is clear ends the run. No data is moved and no flag is raised.
- R11: A last address not aligned to the element size, or element code 3, sets `err_o` and ends the run before any data access. `err_o` stays set until the next accepted `start_i`.
- R12: While `mem_req_o` is high and `mem_ready_i` is low, the request, address and direction are held unchanged.
- R13: One record moves up to 1024 elements (count field 1023), and `remain_o` reads 1024 in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin at the first record slot |
| req_i | input | 1 | Transfer request strobe for records without self start |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data, element copied into every lane |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access accepted this cycle |
| busy_o | output | 1 | Channel active |
| remain_o | output | 11 | Elements still to move in current record |
| irq_a_o | output | 1 | Completion flag A |
| irq_b_o | output | 1 | Completion flag B |
| err_o | output | 1 | Alignment / size error |

## Verification
The bench targets several easy-to-miss cases:
- **Start-address arithmetic.** This is checked with mixed source and destination steps, including factor 4. A design that counted forward from the stored address would write past the destination window.
- **Fixed addresses and byte lanes.** A fixed destination must keep only the last element. Byte and halfword elements at odd lanes show whether lane selection and byte enables are right; getting them wrong corrupts neighbouring bytes.
- **Waiting for the request strobe.** A record without self start must not touch memory before `req_i`, and a 1024-element record must report 1024 rather than wrapping to 0.
- **Chaining.** The order of addresses fetched across a chained pair shows whether the next-record pointer is followed.
- **Invalid and misaligned records.** These must stop the channel with no memory writes, and the next start must clear the sticky flags.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    // Record words and the memory port are fixed at 32 bits by the record layout.
    localparam int WORD_W     = 32;
    localparam int BYTES      = WORD_W / 8;
    localparam int LANE_W     = $clog2(BYTES);
    localparam int CNT_W      = 10;
    localparam int REM_W      = CNT_W + 1;
    localparam int REC_WORDS  = 4;
    localparam int WIDX_W     = $clog2(REC_WORDS);
    localparam int REC_BYTES  = REC_WORDS * BYTES;
    localparam int STRIDE_W   = 6;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CHECK = 3'd2,
        ST_ARM   = 3'd3,
        ST_READ  = 3'd4,
        ST_WRITE = 3'd5
    } chan_state_e;

    typedef struct packed {
        logic             valid;
        logic             chain_en;
        logic             self_start;
        logic             flag_a;
        logic             flag_b;
        logic [1:0]       size_code;
        logic [1:0]       src_step;
        logic [1:0]       dst_step;
        logic [CNT_W-1:0] cnt_m1;
    } ctrl_t;

    typedef struct packed {
        chan_state_e       st;
        logic [WIDX_W-1:0] widx;
        logic [WORD_W-1:0] rec_ptr;
        ctrl_t             ctrl;
        logic [WORD_W-1:0] src_last;
        logic [WORD_W-1:0] dst_last;
        logic [WORD_W-1:0] next_ptr;
        logic [WORD_W-1:0] src_a;
        logic [WORD_W-1:0] dst_a;
        logic [WORD_W-1:0] elem;
        logic [REM_W-1:0]  rem;
        logic              irq_a;
        logic              irq_b;
        logic              err;
    } chan_regs_t;

    // Control word field positions: the only layout the channel decodes.
    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.valid      = w[0];
        c.chain_en   = w[1];
        c.self_start = w[2];
        c.flag_a     = w[3];
        c.flag_b     = w[4];
        c.size_code  = w[6:5];
        c.src_step   = w[9:8];
        c.dst_step   = w[13:12];
        c.cnt_m1     = w[16 +: CNT_W];
        return c;
    endfunction

endpackage

// File: rtl/dma_addr_span.sv
// Per-side address math: stride, first address from last address, and alignment check.
module dma_addr_span
    import dma_chain_pkg::*;
(
    input  logic [1:0]          size_code_i,
    input  logic [1:0]          step_code_i,
    input  logic [CNT_W-1:0]    cnt_m1_i,
    input  logic [WORD_W-1:0]   last_addr_i,
    output logic [WORD_W-1:0]   first_addr_o,
    output logic [STRIDE_W-1:0] stride_o,
    output logic                misaligned_o
);
    logic [STRIDE_W-1:0] factor;
    logic [WORD_W-1:0]   span;

    always_comb begin
        case (step_code_i)
            2'd0:    factor = STRIDE_W'(0);
            2'd1:    factor = STRIDE_W'(1);
            2'd2:    factor = STRIDE_W'(2);
            default: factor = STRIDE_W'(4);
        endcase
        stride_o     = factor << size_code_i;
        span         = WORD_W'(cnt_m1_i) * WORD_W'(stride_o);
        first_addr_o = last_addr_i - span;
        case (size_code_i)
            2'd0:    misaligned_o = 1'b0;
            2'd1:    misaligned_o = last_addr_i[0];
            2'd2:    misaligned_o = |last_addr_i[1:0];
            default: misaligned_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_lane_mux.sv
// Selects the element from a read word and spreads it over the write lanes.
module dma_lane_mux
    import dma_chain_pkg::*;
(
    input  logic [1:0]        size_code_i,
    input  logic [LANE_W-1:0] rd_lane_i,
    input  logic [LANE_W-1:0] wr_lane_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic [WORD_W-1:0] elem_i,
    output logic [WORD_W-1:0] elem_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic [BYTES-1:0]  be_o
);
    logic [WORD_W-1:0] shifted;
    logic [BYTES-1:0]  mask;

    always_comb begin
        shifted = rdata_i >> {rd_lane_i, 3'b000};
        case (size_code_i)
            2'd0: begin
                elem_o  = {{(WORD_W-8){1'b0}}, shifted[7:0]};
                wdata_o = {BYTES{elem_i[7:0]}};
                mask    = BYTES'(1);
            end
            2'd1: begin
                elem_o  = {{(WORD_W-16){1'b0}}, shifted[15:0]};
                wdata_o = {(BYTES/2){elem_i[15:0]}};
                mask    = BYTES'(3);
            end
            default: begin
                elem_o  = shifted;
                wdata_o = elem_i;
                mask    = {BYTES{1'b1}};
            end
        endcase
        be_o = mask << wr_lane_i;
    end
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
    import dma_chain_pkg::*;
#(
    parameter logic [31:0] TABLE_BASE = 32'h0000_0200,
    parameter int unsigned CHAN_ID    = 1
)(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              req_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic [3:0]        mem_be_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              busy_o,
    output logic [REM_W-1:0]  remain_o,
    output logic              irq_a_o,
    output logic              irq_b_o,
    output logic              err_o
);
    localparam logic [WORD_W-1:0] FIRST_REC = TABLE_BASE + WORD_W'(CHAN_ID * REC_BYTES);

    chan_regs_t q, d;

    // Index 0 = source side, 1 = destination side.
    logic [1:0]          side_step  [2];
    logic [WORD_W-1:0]   side_last  [2];
    logic [WORD_W-1:0]   side_first [2];
    logic [STRIDE_W-1:0] side_str   [2];
    logic                side_bad   [2];

    assign side_step[0] = q.ctrl.src_step;
    assign side_step[1] = q.ctrl.dst_step;
    assign side_last[0] = q.src_last;
    assign side_last[1] = q.dst_last;

    for (genvar s = 0; s < 2; s++) begin : g_side
        dma_addr_span u_span (
            .size_code_i  (q.ctrl.size_code),
            .step_code_i  (side_step[s]),
            .cnt_m1_i     (q.ctrl.cnt_m1),
            .last_addr_i  (side_last[s]),
            .first_addr_o (side_first[s]),
            .stride_o     (side_str[s]),
            .misaligned_o (side_bad[s])
        );
    end

    logic [WORD_W-1:0] elem_rd;
    logic [WORD_W-1:0] wdata;
    logic [BYTES-1:0]  be;

    dma_lane_mux u_lane (
        .size_code_i (q.ctrl.size_code),
        .rd_lane_i   (q.src_a[LANE_W-1:0]),
        .wr_lane_i   (q.dst_a[LANE_W-1:0]),
        .rdata_i     (mem_rdata_i),
        .elem_i      (q.elem),
        .elem_o      (elem_rd),
        .wdata_o     (wdata),
        .be_o        (be)
    );

    always_comb begin
        d          = q;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_FETCH;
                    d.widx    = '0;
                    d.rec_ptr = FIRST_REC;
                    d.rem     = '0;
                    d.irq_a   = 1'b0;
                    d.irq_b   = 1'b0;
                    d.err     = 1'b0;
                end
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.rec_ptr + WORD_W'({q.widx, 2'b00});
                if (mem_ready_i) begin
                    case (q.widx)
                        2'd0:    d.ctrl     = unpack_ctrl(mem_rdata_i);
                        2'd1:    d.src_last = mem_rdata_i;
                        2'd2:    d.dst_last = mem_rdata_i;
                        default: d.next_ptr = mem_rdata_i;
                    endcase
                    d.widx = q.widx + WIDX_W'(1);
                    if (q.widx == WIDX_W'(REC_WORDS - 1)) begin
                        d.st = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (!q.ctrl.valid) begin
                    d.st = ST_IDLE;
                end else if (side_bad[0] || side_bad[1]) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.src_a = side_first[0];
                    d.dst_a = side_first[1];
                    d.rem   = {1'b0, q.ctrl.cnt_m1} + REM_W'(1);
                    d.st    = q.ctrl.self_start ? ST_READ : ST_ARM;
                end
            end
            ST_ARM: begin
                if (req_i) begin
                    d.st = ST_READ;
                end
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {q.src_a[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
                if (mem_ready_i) begin
                    d.elem = elem_rd;
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = {q.dst_a[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
                if (mem_ready_i) begin
                    d.rem   = q.rem - REM_W'(1);
                    d.src_a = q.src_a + WORD_W'(side_str[0]);
                    d.dst_a = q.dst_a + WORD_W'(side_str[1]);
                    if (q.rem == REM_W'(1)) begin
                        d.irq_a = q.irq_a | q.ctrl.flag_a;
                        d.irq_b = q.irq_b | q.ctrl.flag_b;
                        if (q.ctrl.chain_en) begin
                            d.rec_ptr = q.next_ptr;
                            d.widx    = '0;
                            d.st      = ST_FETCH;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_wdata_o = wdata;
    assign mem_be_o    = mem_we_o ? be : '0;
    assign busy_o      = (q.st != ST_IDLE);
    assign remain_o    = q.rem;
    assign irq_a_o     = q.irq_a;
    assign irq_b_o     = q.irq_b;
    assign err_o       = q.err;

endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk
    import dma_chain_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [31:0]      mem_addr_o,
    input logic [3:0]       mem_be_o,
    input logic             mem_ready_i,
    input logic             busy_o,
    input logic [REM_W-1:0] remain_o,
    input logic             irq_a_o,
    input logic             irq_b_o,
    input logic             err_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o); // R10

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R12

    AST_LANES_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o) |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                                     || $countones(mem_be_o) == 4)); // R5

    AST_REMAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o && mem_ready_i) |=> (remain_o == $past(remain_o) - REM_W'(1))); // R7

    AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> !busy_o); // R11

    AST_FLAG_A_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_a_o && !start_i) |=> irq_a_o); // R8

    AST_FLAG_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_b_o && !start_i) |=> irq_b_o); // R8

    AST_REMAIN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        remain_o <= REM_W'(1024)); // R13
endmodule

bind dma_chain_chan dma_chain_chan_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .remain_o    (remain_o),
    .irq_a_o     (irq_a_o),
    .irq_b_o     (irq_b_o),
    .err_o       (err_o)
);

// File: tb/tb_dma_chain_chan.sv
module tb_dma_chain_chan;
    import dma_chain_pkg::*;

    localparam logic [31:0] BASE  = 32'h0000_0200;
    localparam int          CH    = 1;
    localparam logic [31:0] REC0  = BASE + 32'(CH * 16);
    localparam int          MEMSZ = 2048;

    typedef struct packed {
        logic [1:0]  w;
        logic [1:0]  si;
        logic [1:0]  di;
        logic [9:0]  cm1;
        logic        ia;
        logic        ib;
        logic [31:0] s_last;
        logic [31:0] d_last;
    } vec_t;

    // R3 R4 R5 R8: size, steps, count-1, flags, last addresses
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 2'd1, 10'd4, 1'b1, 1'b0, 32'h014, 32'h105},
        '{2'd1, 2'd1, 2'd1, 10'd2, 1'b0, 1'b1, 32'h022, 32'h13A},
        '{2'd2, 2'd2, 2'd1, 10'd3, 1'b1, 1'b1, 32'h058, 32'h16C},
        '{2'd2, 2'd0, 2'd1, 10'd2, 1'b1, 1'b0, 32'h060, 32'h188},
        '{2'd0, 2'd1, 2'd0, 10'd3, 1'b0, 1'b1, 32'h073, 32'h1A1},
        '{2'd1, 2'd0, 2'd0, 10'd0, 1'b0, 1'b0, 32'h082, 32'h1B6},
        '{2'd0, 2'd3, 2'd2, 10'd3, 1'b1, 1'b0, 32'h0C3, 32'h1D7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic req = 1'b0;
    logic mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic busy, irq_a, irq_b, err;
    logic [REM_W-1:0] remain;

    always #10 clk = ~clk;

    dma_chain_chan #(.TABLE_BASE(BASE), .CHAN_ID(CH)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_i(req),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata),
        .mem_ready_i(mem_ready), .busy_o(busy), .remain_o(remain),
        .irq_a_o(irq_a), .irq_b_o(irq_b), .err_o(err)
    );

    // Memory model
    logic [7:0]  mem     [0:MEMSZ-1];
    logic [7:0]  exp_mem [0:MEMSZ-1];
    logic        poke_en = 1'b0;
    logic [10:0] poke_addr = '0;
    logic [7:0]  poke_data = '0;
    logic        stall_mode = 1'b0;
    logic [1:0]  stall_ctr = '0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [0:63];

    always @(negedge clk) stall_ctr <= stall_ctr + 2'd1;
    assign mem_ready = !stall_mode || (stall_ctr == 2'd2);
    assign mem_rdata = {mem[{mem_addr[10:2], 2'b11}], mem[{mem_addr[10:2], 2'b10}],
                        mem[{mem_addr[10:2], 2'b01}], mem[{mem_addr[10:2], 2'b00}]};

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[{mem_addr[10:2], 2'(b)}] <= mem_wdata[8*b +: 8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_log[rd_cnt[5:0]] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit wd_fired = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic poke8(input int a, input logic [7:0] v);
        poke_en = 1'b1; poke_addr = 11'(a); poke_data = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic poke32(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) poke8(a + b, v[8*b +: 8]);
    endtask

    task automatic put_rec(input int a, input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] dd, input logic [31:0] nx);
        poke32(a, c); poke32(a + 4, s); poke32(a + 8, dd); poke32(a + 12, nx);
    endtask

    function automatic logic [31:0] mk_ctrl(input bit v, input bit ch, input bit ss,
            input bit fa, input bit fb, input logic [1:0] w, input logic [1:0] si,
            input logic [1:0] di, input logic [9:0] cm1);
        logic [31:0] c;
        c = '0;
        c[0] = v; c[1] = ch; c[2] = ss; c[3] = fa; c[4] = fb;
        c[6:5] = w; c[9:8] = si; c[13:12] = di; c[25:16] = cm1;
        return c;
    endfunction

    function automatic int fac(input logic [1:0] c);
        return (c == 2'd3) ? 4 : int'(c);
    endfunction

    task automatic sync_exp();
        for (int i = 0; i < MEMSZ; i++) exp_mem[i] = mem[i];
    endtask

    // Independent model of one record: first = last - (n-1)*stride, ascending order
    task automatic model(input logic [1:0] w, input logic [1:0] si, input logic [1:0] di,
                         input int cm1, input int s_last, input int d_last);
        int nb, ss, ds;
        nb = 1 << w; ss = fac(si) * nb; ds = fac(di) * nb;
        for (int i = 0; i <= cm1; i++)
            for (int b = 0; b < nb; b++)
                exp_mem[d_last - (cm1 - i) * ds + b] = exp_mem[s_last - (cm1 - i) * ss + b];
    endtask

    task automatic cmp_mem(input string tag, input string what);
        int bad;
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, tag, what, bad, 0);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 5000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check(!busy, tag, "channel returned to idle", busy, 0);
    endtask

    task automatic run_all();
        int w0, r0;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(remain == 0, "R1", "remain after reset", remain, 0);
        check(irq_a == 0 && irq_b == 0, "R1", "flags after reset", {irq_a, irq_b}, 0);
        check(err == 0, "R1", "err after reset", err, 0);
        check(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);

        for (int i = 0; i < 256; i++) poke8(i, 8'(i * 7 + 3));
        for (int i = 256; i < 1024; i++) poke8(i, 8'h00);

        // Table walk: R3 R4 R5 R8 (stalled memory on later rows for R12)
        for (int v = 0; v < NV; v++) begin
            stall_mode = (v >= 4);
            put_rec(REC0, mk_ctrl(1, 0, 1, VECS[v].ia, VECS[v].ib, VECS[v].w, VECS[v].si,
                    VECS[v].di, VECS[v].cm1), VECS[v].s_last, VECS[v].d_last, 32'h0);
            sync_exp();
            model(VECS[v].w, VECS[v].si, VECS[v].di, int'(VECS[v].cm1),
                  int'(VECS[v].s_last), int'(VECS[v].d_last));
            pulse_start();
            wait_idle("R3");
            cmp_mem("R4", $sformatf("row %0d memory image (R3 R5 R12)", v));
            check(irq_a == VECS[v].ia, "R8", $sformatf("row %0d flag A", v), irq_a, VECS[v].ia);
            check(irq_b == VECS[v].ib, "R8", $sformatf("row %0d flag B", v), irq_b, VECS[v].ib);
            check(remain == 0, "R7", $sformatf("row %0d remain at end", v), remain, 0);
        end
        stall_mode = 1'b0;

        // R6: wait for request strobe
        put_rec(REC0, mk_ctrl(1, 0, 0, 0, 0, 2'd1, 2'd1, 2'd1, 10'd3), 32'h0E6, 32'h1E6, 32'h0);
        sync_exp(); model(2'd1, 2'd1, 2'd1, 3, 32'h0E6, 32'h1E6);
        w0 = wr_cnt; r0 = rd_cnt;
        pulse_start();
        repeat (25) @(negedge clk);
        check(busy == 1, "R6", "busy while waiting", busy, 1);
        check(remain == 4, "R6", "remain while waiting (R7)", remain, 4);
        check(wr_cnt == w0 && rd_cnt == r0 + 4, "R6", "no data access before req",
              (wr_cnt - w0) * 100 + (rd_cnt - r0), 4);
        req = 1'b1; @(negedge clk); req = 1'b0;
        wait_idle("R6");
        cmp_mem("R6", "memory after req");

        // R13: maximum count
        put_rec(REC0, mk_ctrl(1, 0, 0, 1, 0, 2'd0, 2'd0, 2'd0, 10'd1023), 32'h0F0, 32'h1F0, 32'h0);
        sync_exp(); model(2'd0, 2'd0, 2'd0, 1023, 32'h0F0, 32'h1F0);
        w0 = wr_cnt;
        pulse_start();
        repeat (10) @(negedge clk);
        check(remain == 1024, "R13", "remain for full record", remain, 1024);
        req = 1'b1; @(negedge clk); req = 1'b0;
        wait_idle("R13");
        check(wr_cnt - w0 == 1024, "R13", "write count", wr_cnt - w0, 1024);
        cmp_mem("R13", "memory after full record");

        // R9 / R2: chained pair under stalls
        stall_mode = 1'b1;
        put_rec(REC0, mk_ctrl(1, 1, 1, 1, 0, 2'd0, 2'd1, 2'd1, 10'd1), 32'h091, 32'h1C1, 32'h300);
        put_rec(32'h300, mk_ctrl(1, 0, 1, 0, 1, 2'd1, 2'd1, 2'd1, 10'd1), 32'h0A2, 32'h1CA, 32'h0);
        sync_exp();
        model(2'd0, 2'd1, 2'd1, 1, 32'h091, 32'h1C1);
        model(2'd1, 2'd1, 2'd1, 1, 32'h0A2, 32'h1CA);
        r0 = rd_cnt;
        pulse_start();
        wait_idle("R9");
        stall_mode = 1'b0;
        for (int k = 0; k < 4; k++)
            check(rd_log[(r0 + k) % 64] == REC0 + 32'(4 * k), "R2", $sformatf("fetch word %0d", k),
                  rd_log[(r0 + k) % 64], REC0 + 32'(4 * k));
        for (int k = 0; k < 4; k++)
            check(rd_log[(r0 + 6 + k) % 64] == 32'h300 + 32'(4 * k), "R9",
                  $sformatf("chained fetch word %0d", k), rd_log[(r0 + 6 + k) % 64],
                  32'h300 + 32'(4 * k));
        cmp_mem("R9", "memory after chain");
        check(irq_a && irq_b, "R9", "both flags after chain", {irq_a, irq_b}, 3);

        // R10: invalid record
        put_rec(REC0, mk_ctrl(0, 0, 1, 1, 1, 2'd0, 2'd1, 2'd1, 10'd2), 32'h012, 32'h112, 32'h0);
        w0 = wr_cnt;
        pulse_start();
        wait_idle("R10");
        check(wr_cnt == w0, "R10", "no writes", wr_cnt - w0, 0);
        check(!irq_a && !irq_b, "R10", "flags cleared, none raised (R8)", {irq_a, irq_b}, 0);
        check(err == 0, "R10", "no error", err, 0);

        // R11: misaligned source, bad size code, misaligned destination
        put_rec(REC0, mk_ctrl(1, 0, 1, 1, 1, 2'd1, 2'd1, 2'd1, 10'd2), 32'h013, 32'h112, 32'h0);
        w0 = wr_cnt;
        pulse_start(); wait_idle("R11");
        check(err == 1, "R11", "odd halfword address", err, 1);
        check(wr_cnt == w0 && !irq_a && !irq_b, "R11", "no writes or flags",
              (wr_cnt - w0) * 4 + {irq_a, irq_b}, 0);
        put_rec(REC0, mk_ctrl(1, 0, 1, 0, 0, 2'd3, 2'd1, 2'd1, 10'd0), 32'h010, 32'h110, 32'h0);
        pulse_start(); wait_idle("R11");
        check(err == 1 && wr_cnt == w0, "R11", "size code 3", err, 1);
        put_rec(REC0, mk_ctrl(1, 0, 1, 0, 0, 2'd2, 2'd1, 2'd1, 10'd0), 32'h010, 32'h1E2, 32'h0);
        pulse_start(); wait_idle("R11");
        check(err == 1 && wr_cnt == w0, "R11", "misaligned word destination", err, 1);
        put_rec(REC0, mk_ctrl(1, 0, 1, 1, 0, 2'd0, 2'd1, 2'd1, 10'd0), 32'h011, 32'h1F8, 32'h0);
        sync_exp(); model(2'd0, 2'd1, 2'd1, 0, 32'h011, 32'h1F8);
        pulse_start(); wait_idle("R11");
        check(err == 0, "R11", "error cleared by next start", err, 0);
        cmp_mem("R5", "single byte at lane 0 after error");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule